// File: doc/BRIEF.md
# Unit-Aware In-Order Issue Gate

This block sits between instruction decode and execution and decides, every cycle, whether the instruction presented to it may issue. Several instructions may be outstanding at once as long as each one targets the pipelined load/store unit, which retires its work strictly in order. An instruction aimed at any other unit must wait until the load/store unit reports that it has nothing left in progress, so results from different units can never overtake one another.

The load/store unit supplies two separate flags. Its busy flag means it cannot accept a new request this cycle. Its in-progress flag means it still holds earlier requests: a valid request in its first stage, or a valid request in its second stage that has not completed. Load/store instructions look only at busy, so they can issue back to back. All other instructions look at both flags. The gate also counts the instructions that have issued but not completed, and it stops issue once that count reaches a limit set by a parameter. A separate output enables exception and interrupt checks for the issuing instruction. This output is held low while earlier loads or stores are still running, so a pending interrupt is never taken in the middle of them.

Top module: `issue_gate`

## Requirements
- R1: Target unit code 2'b01 selects the load/store unit. An instruction with that code is blocked only by `ls_busy`, `ex_busy` or `oth_busy`. The `ls_inprog` flag has no effect on it.
- R2: An instruction with any other unit code (2'b00, 2'b10, 2'b11) is blocked when `ls_busy`, `ex_busy`, `oth_busy` or `ls_inprog` is high.
- R3: In the same cycle, `issue_valid` equals `in_valid` AND NOT blocked AND NOT `flush` AND NOT full.
- R4: The outstanding count goes up by one at a clock edge where `issue_valid` is high and `done` is low. It goes down by one at an edge where `done` is high and `issue_valid` is low.
- R5: The gate is full when the outstanding count is at least PIPELINE_DEPTH+1. While full, `issue_valid` is low and `stall` is high, whatever the inputs are.
- R6: `stall` is high when the gate is full, or when `in_valid` is high and the instruction is blocked. Otherwise `stall` is low.
- R7: `exc_check_en` is high exactly when `issue_valid` is high and `ls_inprog` is low.
- R8: After reset the outstanding count is zero. Exactly PIPELINE_DEPTH+1 unblocked issues are therefore accepted before the gate stalls.
- R9: An edge where an issue and a `done` coincide leaves the outstanding count unchanged.
- R10: `flush` forces `issue_valid` low for that cycle and leaves the outstanding count unchanged.
- R11: A `done` that arrives while the count is zero is ignored. The count does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A decoded instruction is presented |
| in_unit | input | 2 | Target unit code (2'b01 = load/store) |
| flush | input | 1 | Discard the presented instruction |
| ls_busy | input | 1 | Load/store unit cannot accept a request |
| ls_inprog | input | 1 | Load/store unit still holds earlier requests |
| ex_busy | input | 1 | Execute stage busy |
| oth_busy | input | 1 | Other execution unit busy |
| done | input | 1 | One outstanding instruction completed |
| issue_valid | output | 1 | Instruction issues this cycle |
| stall | output | 1 | Hold the instruction upstream |
| exc_check_en | output | 1 | Perform exception and interrupt checks |

## Verification
The bench builds the gate with PIPELINE_DEPTH=2, which puts the full limit at three outstanding instructions. The limit is therefore reached after a few issues, and a sweep over all 512 combinations of the input flags passes repeatedly through the empty, partly filled and full counts. An arithmetic model of the count predicts every output. Directed sequences then fill the gate to the limit and probe three cases: an issue that coincides with a completion, completions that arrive at a count of zero, and flushed instructions. Each case is checked through how many later issues the gate accepts before it stalls.

// File: rtl/issue_gate_pkg.sv
package issue_gate_pkg;
  localparam int UNIT_W = 2;
  typedef enum logic [UNIT_W-1:0] {
    UNIT_ALU  = 2'b00,
    UNIT_LDST = 2'b01,
    UNIT_FPU  = 2'b10,
    UNIT_MISC = 2'b11
  } unit_e;
endpackage

// File: rtl/igate_rst_sync.sv
module igate_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/igate_block_eval.sv
module igate_block_eval
  import issue_gate_pkg::*;
(
  input  logic [UNIT_W-1:0] unit,
  input  logic              ls_busy,
  input  logic              ls_inprog,
  input  logic              ex_busy,
  input  logic              oth_busy,
  output logic              blocked
);
  logic any_busy;
  logic same_unit;

  always_comb begin
    any_busy  = ls_busy | ex_busy | oth_busy;
    same_unit = (unit == UNIT_LDST);
    // R1/R2: in-progress only holds back instructions for other units
    blocked   = any_busy | (ls_inprog & ~same_unit);
  end
endmodule

// File: rtl/igate_outstanding.sv
module igate_outstanding #(
  parameter int PIPELINE_DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic full
);
  localparam int CNT_W = $clog2(PIPELINE_DEPTH + 2);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(PIPELINE_DEPTH + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (inc && !dec) begin
      cnt_d  = cnt_q + CNT_W'(1);
      cnt_en = 1'b1;
    end else if (dec && !inc && (cnt_q != '0)) begin
      cnt_d  = cnt_q - CNT_W'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign full = (cnt_q >= LIMIT);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
  assert_count_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  assert_hold_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec) |=> $stable(cnt_q));
  assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/issue_gate.sv
module issue_gate
  import issue_gate_pkg::*;
#(
  parameter int PIPELINE_DEPTH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [UNIT_W-1:0] in_unit,
  input  logic              flush,
  input  logic              ls_busy,
  input  logic              ls_inprog,
  input  logic              ex_busy,
  input  logic              oth_busy,
  input  logic              done,
  output logic              issue_valid,
  output logic              stall,
  output logic              exc_check_en
);
  logic rst_sync_n;
  logic blocked;
  logic full;

  igate_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  igate_block_eval i_block (
    .unit      (in_unit),
    .ls_busy   (ls_busy),
    .ls_inprog (ls_inprog),
    .ex_busy   (ex_busy),
    .oth_busy  (oth_busy),
    .blocked   (blocked)
  );

  igate_outstanding #(.PIPELINE_DEPTH(PIPELINE_DEPTH)) i_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .inc   (issue_valid),
    .dec   (done),
    .full  (full)
  );

  always_comb begin
    issue_valid  = in_valid & ~blocked & ~flush & ~full;
    stall        = full | (in_valid & blocked);
    exc_check_en = issue_valid & ~ls_inprog;
  end

  assert_full_blocks_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    full |-> (!issue_valid && stall));
  assert_flush_kills_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flush |-> !issue_valid);
  assert_order_kept_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_unit != UNIT_LDST && ls_inprog) |-> !issue_valid);
  assert_exc_gate_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    exc_check_en |-> (issue_valid && !ls_inprog));
endmodule

// File: tb/test_issue_gate.sv
module test_issue_gate;
  localparam int DEPTH = 2;
  localparam int LIM   = DEPTH + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, flush, ls_busy, ls_inprog, ex_busy, oth_busy, done;
  logic [1:0] in_unit;
  logic issue_valid, stall, exc_check_en;

  int checks = 0;
  int fails  = 0;
  int exp_cnt;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  issue_gate #(.PIPELINE_DEPTH(DEPTH)) i_issue_gate (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_unit(in_unit),
    .flush(flush), .ls_busy(ls_busy), .ls_inprog(ls_inprog),
    .ex_busy(ex_busy), .oth_busy(oth_busy), .done(done),
    .issue_valid(issue_valid), .stall(stall), .exc_check_en(exc_check_en)
  );

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic drive(logic v, logic [1:0] u, logic f, logic lb, logic lp,
                       logic eb, logic ob, logic d);
    @(negedge clk);
    in_valid = v; in_unit = u; flush = f; ls_busy = lb; ls_inprog = lp;
    ex_busy = eb; oth_busy = ob; done = d;
    #2;
  endtask

  // model-based check of the current cycle, then model update for the edge
  task automatic step_model;
    logic blk, full, iss;
    string tag;
    blk  = ls_busy | ex_busy | oth_busy | (ls_inprog & (in_unit != 2'b01));
    full = (exp_cnt >= LIM);
    iss  = in_valid & ~blk & ~flush & ~full;
    if (full)                tag = "R5 full";
    else if (flush)          tag = "R3/R10 flush";
    else if (in_unit == 2'b01) tag = "R1 ldst";
    else                     tag = "R2 other";
    check(tag, issue_valid, iss);
    check("R6 stall", stall, full | (in_valid & blk));
    check("R7 exc gate", exc_check_en, iss & ~ls_inprog);
    if (iss && !done) exp_cnt++;
    else if (done && !iss && exp_cnt > 0) exp_cnt--;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 0; in_unit = 0; flush = 0; ls_busy = 0; ls_inprog = 0;
    ex_busy = 0; oth_busy = 0; done = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    exp_cnt = 0;
  endtask

  // issue LIM plain load/stores, then confirm the next one stalls
  task automatic fill_and_probe(string tag);
    for (int k = 0; k < LIM; k++) begin
      drive(1, 2'b01, 0, 0, 0, 0, 0, 0);
      check(tag, issue_valid, 1'b1);
    end
    drive(1, 2'b01, 0, 0, 0, 0, 0, 0);
    check(tag, issue_valid, 1'b0);
    check(tag, stall, 1'b1);
  endtask

  initial begin
    do_reset();
    // R8 reset state
    check("R8 reset issue", issue_valid, 1'b0);
    check("R8 reset stall", stall, 1'b0);
    fill_and_probe("R8 R5 fill after reset");

    // R9: at full, done drains one; then issue+done keeps count
    drive(1, 2'b01, 0, 0, 0, 0, 0, 1);
    check("R5 full with done", issue_valid, 1'b0);
    drive(1, 2'b01, 0, 0, 0, 0, 0, 1);
    check("R9 issue with done", issue_valid, 1'b1);
    drive(1, 2'b01, 0, 0, 0, 0, 0, 0);
    check("R9 one slot left", issue_valid, 1'b1);
    drive(1, 2'b01, 0, 0, 0, 0, 0, 0);
    check("R9 full again", issue_valid, 1'b0);
    check("R4 stall at limit", stall, 1'b1);

    // R4 decrement: drain all, then refill exactly LIM
    for (int k = 0; k < LIM; k++) drive(0, 2'b00, 0, 0, 0, 0, 0, 1);
    fill_and_probe("R4 drained refill");

    // R11: done at zero ignored
    do_reset();
    for (int k = 0; k < 3; k++) drive(0, 2'b00, 0, 0, 0, 0, 0, 1);
    fill_and_probe("R11 no underflow");

    // R10: flushed instructions do not count
    do_reset();
    for (int k = 0; k < 5; k++) begin
      drive(1, 2'b01, 1, 0, 0, 0, 0, 0);
      check("R10 flush issue", issue_valid, 1'b0);
    end
    fill_and_probe("R10 count untouched");

    // R1/R2/R3/R6/R7 sweep over every input pattern
    do_reset();
    for (int rep = 0; rep < 2; rep++)
      for (int c = 0; c < 512; c++) begin
        drive(c[0], c[2:1], c[3], c[4], c[5], c[6], c[7], c[8]);
        step_model();
      end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule